// File: doc/BRIEF.md
# ADC Conversion Clock Divider and Power-Up Sequencer

This block derives a conversion-clock enable for an on-chip analog-to-digital converter from the system clock. It also controls the converter's power-up. A free-running 7-bit divider runs only while the block is enabled and is cleared whenever it is not. A 3-bit select picks a power-of-two division ratio, and the divided rate appears as a single-cycle enable pulse, `adc_tick`.

When the enable bit goes high, the sequencer asks the analog regulator to power up and waits for the regulator's stable flag. It then counts a start-up period in conversion-clock ticks. In differential mode it also counts a track-and-hold settling period before it raises `ready`. Two further outputs protect the caller:

- A guard timer measures the wall-clock minimum start-up time in system clocks from enable. If the first accepted conversion request comes too early, the block flags that result for discard.
- A configuration check reports a division ratio that drives the conversion clock above the limit for the current input mode.

Top module: `adc_clk_seq`

## Requirements
- R1: While `en` is low the divider is held cleared. `adc_tick`, `reg_req`, `ready`, `discard_first` and `cfg_err` are all 0.
- R2: `div_sel` code 0 and code 1 give a ratio D of 2, and code k (2..7) gives D = 2^k. Counting the first clock with `en` high as cycle 1, `adc_tick` is high exactly in cycles that are multiples of D, one clock wide each time.
- R3: `reg_req` goes high one clock after `en` is first sampled high. It stays high while `en` stays high.
- R4: The start-up count begins only after `reg_stable` is sampled high. `ready` rises on the clock that samples the 4*(`su_len`+1)-th tick after that point.
- R5: With `diff_mode` = 1, another 4*(`th_len`+1) ticks are counted after the start-up period before `ready` rises.
- R6: When `en` is sampled low, `reg_req`, `ready` and `discard_first` are all 0 one clock later. The next enable restarts the whole sequence.
- R7: `cfg_err` is high while enabled when CLK_KHZ/D exceeds SE_MAX_KHZ (8000 by default) in single-ended mode, or DIFF_MAX_KHZ (2000 by default) in differential mode. With CLK_KHZ = 16000, this is codes 0..2 in differential mode only.
- R8: A conversion request is accepted on a clock that samples both `conv_req` and `ready` high. `discard_first` is set to 1 when the first accepted request since enable is sampled on clock number c ≤ WAIT_CYC = CLK_KHZ*MIN_US/1000 (320 by default), counted from enable. Otherwise it is set to 0.
- R9: A `conv_req` sampled while `ready` is low is ignored. It leaves `discard_first` unchanged and does not count as the first conversion.
- R10: Every accepted request after the first sets `discard_first` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable |
| div_sel | input | 3 | Division ratio select |
| su_len | input | 5 | Start-up length field N, giving 4*(N+1) ticks |
| th_len | input | 2 | Track-and-hold length field T, giving 4*(T+1) ticks |
| diff_mode | input | 1 | Differential input mode |
| reg_stable | input | 1 | Analog regulator output is stable |
| conv_req | input | 1 | Conversion start request |
| adc_tick | output | 1 | One-cycle conversion clock enable |
| reg_req | output | 1 | Regulator power-up request |
| ready | output | 1 | Start-up complete |
| discard_first | output | 1 | Current conversion result must be discarded |
| cfg_err | output | 1 | Division ratio too fast for the selected mode |

## Verification
The bench drives the discard decision onto both sides of the guard window: a first request on clock 320 must be flagged and one on clock 321 must not. A timer that is off by one would swap these two results. An early request issued before `ready` must not use up the "first conversion" slot. A design that accepted it would clear the flag on the real first conversion. The longest setting (ratio 128, full start-up and track-and-hold in differential mode) exposes a tick counter that is too narrow or a transition that skips a tick, because `ready` would then rise at the wrong clock. Constrained-random settings check the tick phase against the enable edge and check the ready edge against a closed-form formula.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PWR,
      ST_SU,
      ST_TH,
      ST_RDY
   } seq_st_t;

   // log2 of the division ratio for a select code (codes 0 and 1 both divide by 2)
   function automatic int div_log2(int code);
      return (code == 0) ? 1 : code;
   endfunction

endpackage

// File: rtl/adc_pre_div.sv
module adc_pre_div #(
   parameter int PRE_W = 7,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   import adc_seq_pkg::*;

   localparam int MAX_SH = (1 << SEL_W) - 1;

   if (PRE_W < MAX_SH) begin : g_bad_width
      $error("adc_pre_div: PRE_W too small for the select range");
   end

   logic [PRE_W-1:0] cnt;
   logic [PRE_W-1:0] mask;
   int               sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (!en) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end

   always_comb sh = div_log2(int'(sel));

   for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign mask[i] = (sh > i);
   end

   assign tick = en && ((cnt & mask) == mask);

endmodule

// File: rtl/adc_su_fsm.sv
module adc_su_fsm #(
   parameter int SU_W = 5,
   parameter int TH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            tick,
   input  logic [SU_W-1:0] su_len,
   input  logic [TH_W-1:0] th_len,
   input  logic            diff_mode,
   input  logic            reg_stable,
   output logic            reg_req,
   output logic            ready
);
   import adc_seq_pkg::*;

   localparam int CW = ((SU_W > TH_W) ? SU_W : TH_W) + 3;

   if (SU_W < 1 || TH_W < 1) begin : g_bad_fields
      $error("adc_su_fsm: field widths must be at least 1");
   end

   seq_st_t         st, st_nx;
   logic [CW-1:0]   cnt, cnt_nx;
   logic [CW-1:0]   su_last, th_last;

   // 4*(N+1)-1 is N with two ones appended
   assign su_last = CW'({su_len, 2'b11});
   assign th_last = CW'({th_len, 2'b11});

   always_comb begin
      st_nx  = st;
      cnt_nx = cnt;
      if (!en) begin
         st_nx  = ST_IDLE;
         cnt_nx = '0;
      end else begin
         unique case (st)
            ST_IDLE: st_nx = ST_PWR;
            ST_PWR: if (reg_stable) begin
               st_nx  = ST_SU;
               cnt_nx = '0;
            end
            ST_SU: if (tick) begin
               if (cnt == su_last) begin
                  cnt_nx = '0;
                  st_nx  = diff_mode ? ST_TH : ST_RDY;
               end else begin
                  cnt_nx = cnt + 1'b1;
               end
            end
            ST_TH: if (tick) begin
               if (cnt == th_last) begin
                  cnt_nx = '0;
                  st_nx  = ST_RDY;
               end else begin
                  cnt_nx = cnt + 1'b1;
               end
            end
            ST_RDY:  st_nx = ST_RDY;
            default: st_nx = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         st  <= st_nx;
         cnt <= cnt_nx;
      end
   end

   assign reg_req = (st != ST_IDLE);
   assign ready   = (st == ST_RDY);

endmodule

// File: rtl/adc_warm_guard.sv
module adc_warm_guard #(
   parameter int SEL_W        = 3,
   parameter int CLK_KHZ      = 16000,
   parameter int MIN_US       = 20,
   parameter int SE_MAX_KHZ   = 8000,
   parameter int DIFF_MAX_KHZ = 2000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             ready,
   input  logic             conv_req,
   input  logic             diff_mode,
   input  logic [SEL_W-1:0] div_sel,
   output logic             discard_first,
   output logic             cfg_err
);
   import adc_seq_pkg::*;

   localparam int WAIT_CYC = CLK_KHZ * MIN_US / 1000;
   localparam int TW       = $clog2(WAIT_CYC + 1);

   if (WAIT_CYC < 1) begin : g_bad_wait
      $error("adc_warm_guard: minimum start-up window rounds to zero cycles");
   end
   if (DIFF_MAX_KHZ > SE_MAX_KHZ) begin : g_bad_limits
      $error("adc_warm_guard: differential limit above single-ended limit");
   end

   logic [TW-1:0] tmr;
   logic          first_pend;
   logic          accept;
   logic [31:0]   lim, lim_sc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     tmr <= '0;
      else if (!en)                   tmr <= '0;
      else if (tmr != TW'(WAIT_CYC))  tmr <= tmr + 1'b1;
   end

   assign accept = conv_req && ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_pend    <= 1'b1;
         discard_first <= 1'b0;
      end else if (!en) begin
         first_pend    <= 1'b1;
         discard_first <= 1'b0;
      end else if (accept) begin
         first_pend    <= 1'b0;
         discard_first <= first_pend && (tmr != TW'(WAIT_CYC));
      end
   end

   // CLK/D > limit  <=>  CLK > limit*D
   always_comb begin
      lim     = diff_mode ? 32'(DIFF_MAX_KHZ) : 32'(SE_MAX_KHZ);
      lim_sc  = lim << div_log2(int'(div_sel));
      cfg_err = en && (32'(CLK_KHZ) > lim_sc);
   end

endmodule

// File: rtl/adc_clk_seq.sv
module adc_clk_seq #(
   parameter int PRE_W        = 7,
   parameter int SEL_W        = 3,
   parameter int SU_W         = 5,
   parameter int TH_W         = 2,
   parameter int CLK_KHZ      = 16000,
   parameter int MIN_US       = 20,
   parameter int SE_MAX_KHZ   = 8000,
   parameter int DIFF_MAX_KHZ = 2000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] div_sel,
   input  logic [SU_W-1:0]  su_len,
   input  logic [TH_W-1:0]  th_len,
   input  logic             diff_mode,
   input  logic             reg_stable,
   input  logic             conv_req,
   output logic             adc_tick,
   output logic             reg_req,
   output logic             ready,
   output logic             discard_first,
   output logic             cfg_err
);

   adc_pre_div #(
      .PRE_W (PRE_W),
      .SEL_W (SEL_W)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .sel   (div_sel),
      .tick  (adc_tick)
   );

   adc_su_fsm #(
      .SU_W (SU_W),
      .TH_W (TH_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .tick       (adc_tick),
      .su_len     (su_len),
      .th_len     (th_len),
      .diff_mode  (diff_mode),
      .reg_stable (reg_stable),
      .reg_req    (reg_req),
      .ready      (ready)
   );

   adc_warm_guard #(
      .SEL_W        (SEL_W),
      .CLK_KHZ      (CLK_KHZ),
      .MIN_US       (MIN_US),
      .SE_MAX_KHZ   (SE_MAX_KHZ),
      .DIFF_MAX_KHZ (DIFF_MAX_KHZ)
   ) u_guard (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (en),
      .ready         (ready),
      .conv_req      (conv_req),
      .diff_mode     (diff_mode),
      .div_sel       (div_sel),
      .discard_first (discard_first),
      .cfg_err       (cfg_err)
   );

endmodule

// File: rtl/adc_clk_seq_chk.sv
module adc_clk_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic conv_req,
   input logic adc_tick,
   input logic reg_req,
   input logic ready,
   input logic discard_first
);

   // R6: disable clears the handshake, readiness and discard flag next clock
   assert_off_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!reg_req && !ready && !discard_first));

   // R2: the tick is never two cycles wide
   assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      adc_tick |=> !adc_tick);

   // R2: no tick in the first enabled cycle (divider starts cleared)
   assert_no_tick_at_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |-> !adc_tick);

   // R4: readiness only follows a counted tick
   assert_ready_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(adc_tick));

   // R3: ready never without the regulator request
   assert_ready_has_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> reg_req);

   // R8: discard flag only set by an accepted request
   assert_discard_from_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(discard_first) |-> $past(conv_req && ready));

endmodule

bind adc_clk_seq adc_clk_seq_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .en            (en),
   .conv_req      (conv_req),
   .adc_tick      (adc_tick),
   .reg_req       (reg_req),
   .ready         (ready),
   .discard_first (discard_first)
);

// File: tb/adc_clk_seq_bench.sv
module adc_clk_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WAIT_CYC   = 16000 * 20 / 1000;
   localparam int DOG_CYC    = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [2:0] div_sel = '0;
   logic [4:0] su_len = '0;
   logic [1:0] th_len = '0;
   logic       diff_mode = 1'b0;
   logic       reg_stable = 1'b0;
   logic       conv_req = 1'b0;
   logic       adc_tick, reg_req, ready, discard_first, cfg_err;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   adc_clk_seq u_adc_clk_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (en),
      .div_sel       (div_sel),
      .su_len        (su_len),
      .th_len        (th_len),
      .diff_mode     (diff_mode),
      .reg_stable    (reg_stable),
      .conv_req      (conv_req),
      .adc_tick      (adc_tick),
      .reg_req       (reg_req),
      .ready         (ready),
      .discard_first (discard_first),
      .cfg_err       (cfg_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int ratio(input int sel);
      return (sel == 0) ? 2 : (1 << sel);
   endfunction

   // clock (counted from enable) after which ready must be high
   function automatic int ready_edge(input int sel, input int n, input int t,
                                     input bit dif, input int s);
      int d  = ratio(sel);
      int m  = 4 * (n + 1) + (dif ? 4 * (t + 1) : 0);
      return ((s / d) + 1) * d + (m - 1) * d;
   endfunction

   function automatic int cfg_exp(input int sel, input bit dif);
      int lim = dif ? 2000 : 8000;
      return (16000 > lim * ratio(sel)) ? 1 : 0;
   endfunction

   task automatic run_case(input int sel, input int n, input int t, input bit dif,
                           input int s, input int c, input bit early);
      int  d = ratio(sel);
      int  r = ready_edge(sel, n, t, dif, s);
      int  tick_bad = 0, tick_act = 0, tick_exp = 0;
      int  rdy_bad = 0, rdy_act = 0, rdy_exp = 0;
      @(negedge clk);
      div_sel    = sel[2:0];
      su_len     = n[4:0];
      th_len     = t[1:0];
      diff_mode  = dif;
      reg_stable = 1'b0;
      conv_req   = 1'b0;
      en         = 1'b1;
      #1;
      chk("R2 no tick in first enabled cycle", int'(adc_tick), 0);
      chk("R7 configuration error", int'(cfg_err), cfg_exp(sel, dif));
      for (int k = 1; k <= c + 6; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k == 1) chk("R3 regulator request", int'(reg_req), 1);
         if (tick_bad == 0 && int'(adc_tick) != (((k + 1) % d == 0) ? 1 : 0)) begin
            tick_bad = 1;
            tick_act = int'(adc_tick);
            tick_exp = ((k + 1) % d == 0) ? 1 : 0;
         end
         if (rdy_bad == 0 && int'(ready) != ((k >= r) ? 1 : 0)) begin
            rdy_bad = 1;
            rdy_act = int'(ready);
            rdy_exp = (k >= r) ? 1 : 0;
         end
         if (k == r - 1) chk("R4 not ready one clock early", int'(ready), 0);
         if (k == r)     chk(dif ? "R5 ready after track-and-hold" : "R4 ready after start-up",
                             int'(ready), 1);
         if (early && k == 3) chk("R9 request before ready ignored", int'(discard_first), 0);
         if (k == c)     chk("R8 discard on first conversion", int'(discard_first),
                             (c <= WAIT_CYC) ? 1 : 0);
         if (k == c + 4) chk("R10 later conversion not flagged", int'(discard_first), 0);
         reg_stable = (k + 1 >= s);
         conv_req   = (k + 1 == c) || (k + 1 == c + 4) || (early && k + 1 == 3);
      end
      chk("R2 tick pattern", tick_act, tick_exp);
      chk("R4 ready timeline", rdy_act, rdy_exp);
      @(negedge clk);
      en       = 1'b0;
      conv_req = 1'b0;
      #1;
      chk("R1 no tick while disabled", int'(adc_tick), 0);
      @(posedge clk);
      @(negedge clk);
      chk("R6 outputs cleared on disable",
          int'({reg_req, ready, discard_first, cfg_err}), 0);
      reg_stable = 1'b0;
      repeat (3) @(posedge clk);
   endtask

   initial begin : watchdog
      repeat (DOG_CYC) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", DOG_CYC, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd20241));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset state",
          int'({adc_tick, reg_req, ready, discard_first, cfg_err}), 0);
      // R8 window boundary: ratio 2, shortest start-up, ready after clock 10
      run_case(0, 0, 0, 1'b0, 2, WAIT_CYC, 1'b0);
      run_case(0, 0, 0, 1'b0, 2, WAIT_CYC + 1, 1'b0);
      // R9 early request while regulator not stable
      run_case(1, 0, 0, 1'b0, 6, 100, 1'b1);
      // R5 longest differential sequence
      begin
         int r = ready_edge(7, 31, 3, 1'b1, 3);
         run_case(7, 31, 3, 1'b1, 3, r + 1, 1'b0);
      end
      run_case(3, 2, 1, 1'b1, 9, ready_edge(3, 2, 1, 1'b1, 9) + 2, 1'b0);
      // R7 differential with too fast a clock
      run_case(2, 1, 2, 1'b1, 4, ready_edge(2, 1, 2, 1'b1, 4) + 1, 1'b0);
      for (int i = 0; i < 25; i++) begin
         int  sel   = int'($urandom % 6);
         int  n     = int'($urandom % 8);
         int  t     = int'($urandom % 4);
         bit  dif   = 1'($urandom % 2);
         bit  early = 1'($urandom % 2);
         int  s     = 2 + int'($urandom % 19);
         int  c;
         if (early && s < 5) s = 5;
         c = ready_edge(sel, n, t, dif, s) + 1 + int'($urandom % 400);
         run_case(sel, n, t, dif, s, c, early);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule